// File: doc/BRIEF.md
# Operand-Capture Issue Queue

This block is a small out-of-order issue buffer that serves one class of execution unit in a machine that decodes two instructions per cycle. A central allocator sends it up to two renamed instructions per cycle. Each of the two source operands arrives either as a finished value or as a rename tag that names the result it waits for. The queue snoops two result-broadcast lanes every cycle. When a broadcast tag matches a waiting operand, the queue replaces the tag with the broadcast data. When every operand of an entry holds data, the entry becomes a candidate for issue. One candidate per cycle goes to the execution unit over a valid/ready handshake, and the oldest candidate always goes first.

The queue reports how many of its slots are free, computed from the slots registered at the start of the cycle. The central allocator uses this count to stall decode when too few slots are free. A flush input empties the whole queue in a single cycle. Instructions enter in program order: lane 0 is older than lane 1. Each entry keeps an age rank equal to the number of younger entries that are still present, so selecting the largest rank gives program order among ready entries.

Top module: `rs_station`

## Requirements
- R1: After reset, free_count equals DEPTH and iss_valid is 0.
- R2: Requested lanes, taken in order lane 0 then lane 1, are accepted only while free slots remain. Lanes beyond the free count are dropped. One cycle later, free_count has dropped by the number of lanes accepted.
- R3: An instruction whose two operands both arrive as data (alloc_a_ok = 1 and alloc_b_ok = 1) presents iss_valid in the cycle after it is accepted.
- R4: An entry with an operand still holding a tag (ok = 0, tag in the low TAG_W bits of the operand field) never raises iss_valid.
- R5: When bc_valid is high on either lane and bc_tag equals a waiting operand's tag, the operand takes bc_data. The entry can issue in the next cycle, and iss_a/iss_b carry that data.
- R6: A broadcast in the same cycle as allocation is captured for a matching incoming tag. The instruction can issue in the next cycle.
- R7: Among ready entries, the one allocated earliest issues first, even if a younger entry became ready earlier. Lane 0 counts as older than lane 1 within one cycle.
- R8: Once raised, iss_valid stays high while iss_ready is low (no flush). An entry leaves on the edge where iss_valid and iss_ready are both high, and free_count rises by one in the following cycle.
- R9: While flush is high, iss_valid is 0 and allocation requests are dropped. In the next cycle free_count equals DEPTH.
- R10: When both broadcast lanes carry the tag of the same waiting operand, the operand takes the lane 0 data.
- R11: A broadcast with bc_valid low, or with a tag that differs from the waiting tag, leaves the operand waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties every slot at the next edge |
| alloc_valid | input | 2 | Per-lane allocation request, lane 0 older |
| alloc_op | input | 2 x OP_W | Per-lane operation payload |
| alloc_a_ok | input | 2 | Operand A holds data (1) or a tag (0) |
| alloc_a | input | 2 x DATA_W | Operand A data, or tag in the low TAG_W bits |
| alloc_b_ok | input | 2 | Operand B holds data (1) or a tag (0) |
| alloc_b | input | 2 x DATA_W | Operand B data, or tag in the low TAG_W bits |
| free_count | output | clog2(DEPTH+1) | Number of unoccupied slots |
| bc_valid | input | 2 | Per-lane result broadcast valid |
| bc_tag | input | 2 x TAG_W | Per-lane broadcast tag |
| bc_data | input | 2 x DATA_W | Per-lane broadcast data |
| iss_valid | output | 1 | An entry is offered to the execution unit |
| iss_ready | input | 1 | Execution unit accepts the offered entry |
| iss_op | output | OP_W | Offered operation |
| iss_a | output | DATA_W | Offered operand A |
| iss_b | output | DATA_W | Offered operand B |

## Verification
The bench builds the queue with DEPTH = 4, DATA_W = 8, TAG_W = 3 and OP_W = 4. With these values the bench sweeps every pair of waiting tag and broadcast tag on both lanes, with the broadcast valid both on and off. It runs the same tag sweep for capture at allocation time. With only four slots, a few cycles are enough to fill the queue, over-request it, and drain it in age order, so the dropped-lane and free-count rules are checked at their limits.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int RS_DEPTH_DEF = 4;
    localparam int RS_DATA_DEF  = 16;
    localparam int RS_TAG_DEF   = 5;
    localparam int RS_OP_DEF    = 6;

    // What an operand slot currently carries
    typedef enum logic {
        OPND_WAIT = 1'b0,
        OPND_HAVE = 1'b1
    } opnd_state_e;

endpackage

// File: rtl/rs_capture.sv
// Tag match of one operand against both broadcast lanes; lane 0 wins.
module rs_capture #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 5
) (
    input  logic                   in_have,
    input  logic [DATA_W-1:0]      in_val,
    input  logic [1:0]             bc_valid,
    input  logic [1:0][TAG_W-1:0]  bc_tag,
    input  logic [1:0][DATA_W-1:0] bc_data,
    output logic                   out_have,
    output logic [DATA_W-1:0]      out_val
);
    always_comb begin
        out_have = in_have;
        out_val  = in_val;
        if (!in_have) begin
            if (bc_valid[1] && bc_tag[1] == in_val[TAG_W-1:0]) begin
                out_have = 1'b1;
                out_val  = bc_data[1];
            end
            if (bc_valid[0] && bc_tag[0] == in_val[TAG_W-1:0]) begin
                out_have = 1'b1;
                out_val  = bc_data[0];
            end
        end
    end
endmodule

// File: rtl/rs_slot_pick.sv
// Local allocation: first and second free slot, handed to requests in lane order.
module rs_slot_pick #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic [DEPTH-1:0]           occ,
    input  logic [1:0]                 req,
    output logic [1:0]                 grant,
    output logic [1:0][IDX_W-1:0]      slot
);
    logic             f0, f1;
    logic [IDX_W-1:0] s0, s1;

    always_comb begin
        f0 = 1'b0;
        f1 = 1'b0;
        s0 = '0;
        s1 = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!occ[i]) begin
                if (!f0) begin
                    f0 = 1'b1;
                    s0 = IDX_W'(i);
                end else if (!f1) begin
                    f1 = 1'b1;
                    s1 = IDX_W'(i);
                end
            end
        end
        grant   = 2'b00;
        slot[0] = s0;
        slot[1] = req[0] ? s1 : s0;
        if (req[0]) grant[0] = f0;
        if (req[1]) grant[1] = req[0] ? f1 : f0;
    end
endmodule

// File: rtl/rs_oldest_pick.sv
// Dispatch select: ready entry with the largest age rank.
module rs_oldest_pick #(
    parameter int DEPTH = 4,
    parameter int AGE_W = 2,
    parameter int IDX_W = 2
) (
    input  logic [DEPTH-1:0]            ready,
    input  logic [DEPTH-1:0][AGE_W-1:0] age,
    output logic                        any,
    output logic [IDX_W-1:0]            idx
);
    logic [AGE_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ready[i] && (!any || age[i] > best)) begin
                any  = 1'b1;
                best = age[i];
                idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int DEPTH  = RS_DEPTH_DEF,
    parameter int DATA_W = RS_DATA_DEF,
    parameter int TAG_W  = RS_TAG_DEF,
    parameter int OP_W   = RS_OP_DEF,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic [1:0]             alloc_valid,
    input  logic [1:0][OP_W-1:0]   alloc_op,
    input  logic [1:0]             alloc_a_ok,
    input  logic [1:0][DATA_W-1:0] alloc_a,
    input  logic [1:0]             alloc_b_ok,
    input  logic [1:0][DATA_W-1:0] alloc_b,
    output logic [CNT_W-1:0]       free_count,
    input  logic [1:0]             bc_valid,
    input  logic [1:0][TAG_W-1:0]  bc_tag,
    input  logic [1:0][DATA_W-1:0] bc_data,
    output logic                   iss_valid,
    input  logic                   iss_ready,
    output logic [OP_W-1:0]        iss_op,
    output logic [DATA_W-1:0]      iss_a,
    output logic [DATA_W-1:0]      iss_b
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int AGE_W = IDX_W;

    typedef struct packed {
        opnd_state_e       st;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic [OP_W-1:0] op;
        opnd_t           a;
        opnd_t           b;
    } ent_t;

    ent_t                       ent_q [DEPTH];
    logic [DEPTH-1:0]           occ_q;
    logic [DEPTH-1:0][AGE_W-1:0] age_q;

    // Update unit outputs, one pair per entry and per allocation lane
    logic [DEPTH-1:0]  a_hv, b_hv;
    logic [DATA_W-1:0] a_vl [DEPTH];
    logic [DATA_W-1:0] b_vl [DEPTH];
    logic [1:0]        la_hv, lb_hv;
    logic [DATA_W-1:0] la_vl [2];
    logic [DATA_W-1:0] lb_vl [2];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent_upd
        rs_capture #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_cap_a (
            .in_have (ent_q[g].a.st == OPND_HAVE),
            .in_val  (ent_q[g].a.val),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
            .out_have(a_hv[g]), .out_val(a_vl[g])
        );
        rs_capture #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_cap_b (
            .in_have (ent_q[g].b.st == OPND_HAVE),
            .in_val  (ent_q[g].b.val),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
            .out_have(b_hv[g]), .out_val(b_vl[g])
        );
    end

    for (genvar k = 0; k < 2; k++) begin : g_lane_upd
        rs_capture #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_cap_a (
            .in_have (alloc_a_ok[k]), .in_val(alloc_a[k]),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
            .out_have(la_hv[k]), .out_val(la_vl[k])
        );
        rs_capture #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_cap_b (
            .in_have (alloc_b_ok[k]), .in_val(alloc_b[k]),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
            .out_have(lb_hv[k]), .out_val(lb_vl[k])
        );
    end

    // Local allocation
    logic [1:0]            grant;
    logic [1:0][IDX_W-1:0] slot;
    logic [AGE_W-1:0]      n_alloc;

    rs_slot_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
        .occ(occ_q), .req(alloc_valid & {2{~flush}}),
        .grant(grant), .slot(slot)
    );

    assign n_alloc = AGE_W'({1'b0, grant[0]} + {1'b0, grant[1]});

    // Dispatch
    logic [DEPTH-1:0] ready;
    logic             any_rdy;
    logic [IDX_W-1:0] sel;
    logic             fire;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ready[i] = occ_q[i] && ent_q[i].a.st == OPND_HAVE
                                && ent_q[i].b.st == OPND_HAVE;
        end
    end

    rs_oldest_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_sel (
        .ready(ready), .age(age_q), .any(any_rdy), .idx(sel)
    );

    assign iss_valid  = any_rdy && !flush;
    assign iss_op     = ent_q[sel].op;
    assign iss_a      = ent_q[sel].a.val;
    assign iss_b      = ent_q[sel].b.val;
    assign fire       = iss_valid && iss_ready;
    assign free_count = CNT_W'(DEPTH) - CNT_W'($countones(occ_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
            age_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (flush) begin
            occ_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i].a <= '{st: opnd_state_e'(a_hv[i]), val: a_vl[i]};
                ent_q[i].b <= '{st: opnd_state_e'(b_hv[i]), val: b_vl[i]};
                // Rank = count of younger entries still present
                age_q[i] <= age_q[i] + n_alloc
                          - AGE_W'(fire && age_q[sel] < age_q[i]);
                if (fire && sel == IDX_W'(i)) occ_q[i] <= 1'b0;
            end
            for (int k = 0; k < 2; k++) begin
                if (grant[k]) begin
                    occ_q[slot[k]] <= 1'b1;
                    ent_q[slot[k]] <= '{op: alloc_op[k],
                                        a:  '{st: opnd_state_e'(la_hv[k]), val: la_vl[k]},
                                        b:  '{st: opnd_state_e'(lb_hv[k]), val: lb_vl[k]}};
                    age_q[slot[k]] <= (k == 0 && grant[1]) ? AGE_W'(1) : '0;
                end
            end
        end
    end

endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic [1:0]       alloc_valid,
    input logic [1:0]       alloc_a_ok,
    input logic [1:0]       alloc_b_ok,
    input logic [CNT_W-1:0] free_count,
    input logic             iss_valid,
    input logic             iss_ready
);
    logic [CNT_W-1:0] want, take;

    always_comb begin
        want = CNT_W'({1'b0, alloc_valid[0]} + {1'b0, alloc_valid[1]});
        take = (want > free_count) ? free_count : want;
    end

    // R2 and R8: occupancy bookkeeping seen from the ports
    p_free_step_r2: assert property (@(posedge clk) disable iff (rst)
        !flush |=> free_count == $past(free_count) - $past(take)
                                 + CNT_W'($past(iss_valid && iss_ready)));

    p_ready_next_r3: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid[0] && free_count != 0 && alloc_a_ok[0] && alloc_b_ok[0] && !flush)
        |=> (iss_valid || flush));

    p_empty_idle_r4: assert property (@(posedge clk) disable iff (rst)
        free_count == CNT_W'(DEPTH) |-> !iss_valid);

    p_keep_valid_r8: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |=> (iss_valid || flush));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (free_count == CNT_W'(DEPTH) && !iss_valid));

endmodule

bind rs_station rs_station_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_a_ok(alloc_a_ok), .alloc_b_ok(alloc_b_ok),
    .free_count(free_count), .iss_valid(iss_valid), .iss_ready(iss_ready)
);

// File: tb/tb_rs_station.sv
module tb_rs_station;
    localparam int DEPTH = 4, DATA_W = 8, TAG_W = 3, OP_W = 4;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
    logic [1:0]             alloc_valid, alloc_a_ok, alloc_b_ok;
    logic [1:0][OP_W-1:0]   alloc_op;
    logic [1:0][DATA_W-1:0] alloc_a, alloc_b;
    logic [CNT_W-1:0]       free_count;
    logic [1:0]             bc_valid;
    logic [1:0][TAG_W-1:0]  bc_tag;
    logic [1:0][DATA_W-1:0] bc_data;
    logic                   iss_valid, iss_ready;
    logic [OP_W-1:0]        iss_op;
    logic [DATA_W-1:0]      iss_a, iss_b;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    rs_station #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) dut (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op),
        .alloc_a_ok(alloc_a_ok), .alloc_a(alloc_a),
        .alloc_b_ok(alloc_b_ok), .alloc_b(alloc_b),
        .free_count(free_count),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        flush = 1'b0; iss_ready = 1'b0;
        alloc_valid = '0; alloc_op = '0; alloc_a_ok = '0; alloc_a = '0;
        alloc_b_ok = '0; alloc_b = '0;
        bc_valid = '0; bc_tag = '0; bc_data = '0;
    endtask

    task automatic put(input int k, input logic [3:0] op, input logic aok,
                       input logic [7:0] a, input logic bok, input logic [7:0] b);
        alloc_valid[k] = 1'b1; alloc_op[k] = op;
        alloc_a_ok[k] = aok; alloc_a[k] = a;
        alloc_b_ok[k] = bok; alloc_b[k] = b;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Take one issue and check its identity and the free count before it
    task automatic take(input string req, input logic [3:0] op, input int exp_free);
        idle(); iss_ready = 1'b1; #1;
        chk(req, 32'(iss_valid), 1);
        chk(req, 32'(iss_op), 32'(op));
        chk("R8 free before issue", 32'(free_count), exp_free);
        tick();
    endtask

    task automatic expect_empty(input string req);
        idle(); #1;
        chk(req, 32'(iss_valid), 0);
        chk(req, 32'(free_count), DEPTH);
    endtask

    task automatic clean(input logic hit);
        idle();
        if (hit) iss_ready = 1'b1; else flush = 1'b1;
        tick();
        expect_empty("R8/R9 cleanup");
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; #1;
        chk("R1 free after reset", 32'(free_count), DEPTH);
        chk("R1 idle after reset", 32'(iss_valid), 0);

        // R5/R11 sweep: waiting tag against broadcast tag, lane and valid
        for (int ln = 0; ln < 2; ln++) begin
            for (int bv = 0; bv < 2; bv++) begin
                for (int pt = 0; pt < 8; pt++) begin
                    for (int bt = 0; bt < 8; bt++) begin
                        logic [7:0] d;
                        logic hit;
                        d = 8'(pt * 16 + bt * 2 + ln);
                        hit = (bv == 1) && (pt == bt);
                        idle(); put(0, 4'hA, 1'b1, 8'h11, 1'b0, 8'(pt)); tick();
                        idle(); bc_valid[ln] = 1'(bv); bc_tag[ln] = 3'(bt); bc_data[ln] = d; #1;
                        chk("R4 waiting entry not offered", 32'(iss_valid), 0);
                        tick();
                        idle(); #1;
                        chk("R5/R11 capture decision", 32'(iss_valid), 32'(hit));
                        if (hit) begin
                            chk("R5 captured data", 32'(iss_b), 32'(d));
                            chk("R5 untouched operand", 32'(iss_a), 32'h11);
                        end
                        clean(hit);
                    end
                end
            end
        end

        // R6 sweep: capture in the allocation cycle
        for (int pt = 0; pt < 8; pt++) begin
            for (int bt = 0; bt < 8; bt++) begin
                int ln;
                logic [7:0] d;
                logic hit;
                ln = (pt + bt) % 2;
                d = 8'(8'h40 + pt * 8 + bt);
                hit = (pt == bt);
                idle(); put(1, 4'h5, 1'b0, 8'(pt), 1'b1, 8'h22);
                bc_valid[ln] = 1'b1; bc_tag[ln] = 3'(bt); bc_data[ln] = d;
                tick();
                idle(); #1;
                chk("R6 capture at allocation", 32'(iss_valid), 32'(hit));
                if (hit) chk("R6 captured data", 32'(iss_a), 32'(d));
                clean(hit);
            end
        end

        // R10: both lanes carry the same tag
        idle(); put(0, 4'h6, 1'b0, 8'h03, 1'b1, 8'h00); tick();
        idle(); bc_valid = 2'b11; bc_tag[0] = 3'd3; bc_tag[1] = 3'd3;
        bc_data[0] = 8'hA0; bc_data[1] = 8'hB0; tick();
        idle(); #1;
        chk("R10 lane 0 wins", 32'(iss_a), 32'hA0);
        clean(1'b1);

        // R3/R7: in-order ready entries leave in allocation order
        idle(); put(0, 4'h1, 1'b1, 8'h01, 1'b1, 8'h01); put(1, 4'h2, 1'b1, 8'h02, 1'b1, 8'h02); tick();
        idle(); put(0, 4'h3, 1'b1, 8'h03, 1'b1, 8'h03); iss_ready = 1'b1; #1;
        chk("R3 offered next cycle", 32'(iss_valid), 1);
        chk("R7 lane 0 first", 32'(iss_op), 1);
        tick();
        take("R7 lane 1 second", 4'h2, 2);
        take("R7 later cycle last", 4'h3, 3);
        expect_empty("R8 drained");

        // R7/R8: younger ready passes, then older one overtakes once ready
        idle(); put(0, 4'h7, 1'b0, 8'h05, 1'b1, 8'h33); put(1, 4'h8, 1'b1, 8'h08, 1'b1, 8'h08); tick();
        idle(); put(0, 4'h9, 1'b1, 8'h09, 1'b1, 8'h09); #1;
        chk("R7 younger ready offered", 32'(iss_op), 8);
        tick();
        idle(); bc_valid[1] = 1'b1; bc_tag[1] = 3'd5; bc_data[1] = 8'h55; #1;
        chk("R8 held while not accepted", 32'(iss_valid), 1);
        chk("R8 held entry", 32'(iss_op), 8);
        tick();
        idle(); #1;
        chk("R5 captured value", 32'(iss_a), 32'h55);
        take("R7 oldest after capture", 4'h7, 1);
        take("R7 next oldest", 4'h8, 2);
        take("R7 youngest", 4'h9, 3);
        expect_empty("R8 drained");

        // R2: fill, over-request, drain
        idle(); put(0, 4'h1, 1'b1, 0, 1'b1, 0); put(1, 4'h2, 1'b1, 0, 1'b1, 0); tick();
        idle(); #1; chk("R2 two accepted", 32'(free_count), 2);
        put(0, 4'h3, 1'b1, 0, 1'b1, 0); put(1, 4'h4, 1'b1, 0, 1'b1, 0); tick();
        idle(); #1; chk("R2 full", 32'(free_count), 0);
        put(0, 4'h5, 1'b1, 0, 1'b1, 0); put(1, 4'h6, 1'b1, 0, 1'b1, 0); tick();
        idle(); #1; chk("R2 dropped when full", 32'(free_count), 0);
        take("R2 drain 1", 4'h1, 0);
        take("R2 drain 2", 4'h2, 1);
        take("R2 drain 3", 4'h3, 2);
        take("R2 drain 4", 4'h4, 3);
        expect_empty("R2 nothing extra accepted");

        // R2: one free slot, two requests: lane 0 only
        idle(); put(0, 4'h1, 1'b1, 0, 1'b1, 0); put(1, 4'h2, 1'b1, 0, 1'b1, 0); tick();
        idle(); put(0, 4'h3, 1'b1, 0, 1'b1, 0); tick();
        idle(); #1; chk("R2 one free", 32'(free_count), 1);
        put(0, 4'h4, 1'b1, 0, 1'b1, 0); put(1, 4'h5, 1'b1, 0, 1'b1, 0); tick();
        idle(); #1; chk("R2 lane 1 dropped", 32'(free_count), 0);
        take("R2 partial drain 1", 4'h1, 0);
        take("R2 partial drain 2", 4'h2, 1);
        take("R2 partial drain 3", 4'h3, 2);
        take("R2 partial drain 4", 4'h4, 3);
        expect_empty("R2 lane 1 never entered");

        // R9: flush with a colliding allocation and a ready consumer
        idle(); put(0, 4'h1, 1'b1, 0, 1'b1, 0); put(1, 4'h2, 1'b1, 0, 1'b1, 0); tick();
        idle(); put(0, 4'h3, 1'b1, 0, 1'b1, 0); tick();
        idle(); flush = 1'b1; iss_ready = 1'b1; put(0, 4'h4, 1'b1, 0, 1'b1, 0); #1;
        chk("R9 no offer during flush", 32'(iss_valid), 0);
        tick();
        expect_empty("R9 empty after flush");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule